// File: doc/BRIEF.md
# Instruction Privilege Level Checker

This block decides whether a fetched instruction may run at the core's current privilege ring. Three rings exist: ring 0 has the most privilege, ring 1 is the operating-system kernel level, and ring 2 is the user level. Each opcode has a stored minimum level. An instruction may run when the current ring number is less than or equal to the stored level for its opcode. An instruction stored at level 2 therefore runs in any ring, and one stored at level 0 runs only in ring 0.

The opcode is bits [31:24] of the 32-bit instruction word. It indexes a 256-entry table of 2-bit levels, and a write port loads the table during initialization. The result appears one cycle after the valid strobe. It is either an allow pulse or a fault pulse, and the faulting opcode is captured on an output. A level code of 3, or a ring code of 3, is not a legal value and always gives a fault.

Top module: `insn_priv_check`

## Requirements
- R1: After reset is released, `allow_o`, `fault_o` and `fault_opcode_o` are all 0.
- R2: The opcode is `insn_i[31:24]` and selects the table entry. Bits [23:0] have no effect on the result.
- R3: If `insn_valid_i` is high at a clock edge, the ring is below 3, the level is below 3, and ring <= level, then `allow_o` is 1 and `fault_o` is 0 during the following cycle.
- R4: If `insn_valid_i` is high at a clock edge and the ring number is greater than the stored level, then `fault_o` is 1 and `allow_o` is 0 during the following cycle.
- R5: A stored level of 3 or a ring of 3 always produces a fault.
- R6: `allow_o` and `fault_o` are never 1 together. Both are 0 in any cycle that follows an edge at which `insn_valid_i` was low.
- R7: On a fault, `fault_opcode_o` takes the faulting opcode in the same cycle that `fault_o` rises. It holds that value through allows and idle cycles.
- R8: A table write (`tbl_we_i`, `tbl_addr_i`, `tbl_level_i`) takes effect at the clock edge. An instruction checked at that same edge uses the level held before the write.
- R9: Reset sets every table entry to level 0. Until the table is loaded, only ring 0 is allowed.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| insn_i | input | 32 | Fetched instruction word |
| insn_valid_i | input | 1 | Instruction valid strobe |
| ring_i | input | 2 | Current privilege ring (0, 1 or 2) |
| tbl_we_i | input | 1 | Table write enable |
| tbl_addr_i | input | 8 | Opcode entry to write |
| tbl_level_i | input | 2 | Minimum level to store |
| allow_o | output | 1 | Instruction may run (registered) |
| fault_o | output | 1 | Privilege fault (registered) |
| fault_opcode_o | output | 8 | Opcode of the most recent faulting instruction |

## Verification
A table write and a check of the same opcode can fall on the same clock edge. The bench provokes this by raising the write strobe for an opcode in the same cycle that it presents that opcode as a valid instruction. The stored level is 0 and the new level is 2, and the instruction runs in ring 2. The check passes only if that instruction faults against the old level and the next instruction with the same opcode is allowed.

// File: rtl/priv_chk_pkg.sv
package priv_chk_pkg;
  localparam int unsigned INSN_W = 32;
  localparam int unsigned OPC_W  = 8;
  localparam int unsigned LVL_W  = 2;
  localparam int unsigned N_OPC  = 1 << OPC_W;
  localparam logic [LVL_W-1:0] LVL_BAD = '1;

  typedef logic [LVL_W-1:0] level_t;
  typedef logic [OPC_W-1:0] opcode_t;
endpackage

// File: rtl/priv_level_table.sv
module priv_level_table #(
  parameter int unsigned ENTRIES = 256,
  parameter int unsigned LVL_W   = 2,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [LVL_W-1:0] wr_level_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [LVL_W-1:0] rd_level_o
);
  logic [LVL_W-1:0] level_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     level_q[g] <= '0;
      else if (we_i && wr_idx_i == IDX_W'(g))          level_q[g] <= wr_level_i;
    end
  end

  // read sees the value before a same-edge write
  assign rd_level_o = level_q[rd_idx_i];

  // R8
  wr_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> level_q[$past(wr_idx_i)] == $past(wr_level_i));
endmodule

// File: rtl/priv_compare.sv
module priv_compare #(
  parameter int unsigned LVL_W = 2
) (
  input  logic [LVL_W-1:0] ring_i,
  input  logic [LVL_W-1:0] level_i,
  output logic             permit_o
);
  localparam logic [LVL_W-1:0] BAD = '1;

  logic ring_ok, level_ok;

  always_comb begin
    ring_ok  = (ring_i  != BAD);
    level_ok = (level_i != BAD);
    permit_o = ring_ok && level_ok && (ring_i <= level_i);
  end
endmodule

// File: rtl/insn_priv_check.sv
module insn_priv_check
  import priv_chk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [INSN_W-1:0] insn_i,
  input  logic              insn_valid_i,
  input  logic [LVL_W-1:0]  ring_i,
  input  logic              tbl_we_i,
  input  logic [OPC_W-1:0]  tbl_addr_i,
  input  logic [LVL_W-1:0]  tbl_level_i,
  output logic              allow_o,
  output logic              fault_o,
  output logic [OPC_W-1:0]  fault_opcode_o
);
  opcode_t opcode;
  level_t  level;
  logic    permit;

  assign opcode = insn_i[INSN_W-1 -: OPC_W];

  priv_level_table #(.ENTRIES(N_OPC), .LVL_W(LVL_W)) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (tbl_we_i),
    .wr_idx_i   (tbl_addr_i),
    .wr_level_i (tbl_level_i),
    .rd_idx_i   (opcode),
    .rd_level_o (level)
  );

  priv_compare #(.LVL_W(LVL_W)) u_cmp (
    .ring_i   (ring_i),
    .level_i  (level),
    .permit_o (permit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      allow_o        <= 1'b0;
      fault_o        <= 1'b0;
      fault_opcode_o <= '0;
    end else begin
      allow_o <= insn_valid_i && permit;
      fault_o <= insn_valid_i && !permit;
      if (insn_valid_i && !permit) fault_opcode_o <= opcode;
    end
  end

  // R6
  excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(allow_o && fault_o));
  // R6
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !insn_valid_i |=> !allow_o && !fault_o);
  // R5
  bad_ring_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    insn_valid_i && ring_i == LVL_BAD |=> fault_o);
  // R4
  over_ring_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    insn_valid_i && ring_i > level |=> fault_o && !allow_o);
  // R7
  opc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_o |-> $stable(fault_opcode_o));
endmodule

// File: tb/insn_priv_check_tb_top.sv
module insn_priv_check_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] insn = '0;
  logic        valid = 1'b0;
  logic [1:0]  ring = '0;
  logic        we = 1'b0;
  logic [7:0]  waddr = '0;
  logic [1:0]  wlvl = '0;
  logic        allow, fault;
  logic [7:0]  fopc;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  insn_priv_check dut_i (
    .clk_i(clk), .rst_ni(rst_n), .insn_i(insn), .insn_valid_i(valid),
    .ring_i(ring), .tbl_we_i(we), .tbl_addr_i(waddr), .tbl_level_i(wlvl),
    .allow_o(allow), .fault_o(fault), .fault_opcode_o(fopc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [1:0] l);
    @(negedge clk); we = 1'b1; waddr = a; wlvl = l;
    @(negedge clk); we = 1'b0;
  endtask

  // present one instruction, sample result the cycle after the edge
  task automatic run(input string req, input logic [31:0] word, input logic [1:0] r,
                     input logic exp_allow);
    @(negedge clk); insn = word; valid = 1'b1; ring = r;
    @(negedge clk); valid = 1'b0;
    chk(req, {30'b0, allow, fault}, {30'b0, exp_allow, ~exp_allow});
    if (!exp_allow) chk({req, " opcode"}, 32'(fopc), 32'(word[31:24]));
  endtask

  task automatic t_reset();
    chk("R1 allow", 32'(allow), 0);
    chk("R1 fault", 32'(fault), 0);
    chk("R1 opcode", 32'(fopc), 0);
  endtask

  task automatic t_unloaded();
    run("R9 ring0", 32'h1100_0000, 2'd0, 1'b1);
    run("R9 ring1", 32'h2200_0000, 2'd1, 1'b0);
    run("R9 ring2", 32'h3300_0000, 2'd2, 1'b0);
  endtask

  task automatic t_matrix();
    for (int l = 0; l < 4; l++) wr(8'h40 + 8'(l), 2'(l));
    for (int l = 0; l < 4; l++)
      for (int r = 0; r < 4; r++) begin
        logic ok;
        ok = (l != 3) && (r != 3) && (r <= l);
        run(ok ? "R3 permit" : ((l == 3 || r == 3) ? "R5 invalid" : "R4 over"),
            {8'h40 + 8'(l), 24'hABCDEF}, 2'(r), ok);
      end
  endtask

  task automatic t_field();
    wr(8'hC5, 2'd1);
    run("R2 low bits", 32'hC5FF_FFFF, 2'd1, 1'b1);
    run("R2 low bits zero", 32'hC500_0000, 2'd1, 1'b1);
    run("R2 neighbour opcode", 32'hC4FF_FFFF, 2'd1, 1'b0);
  endtask

  task automatic t_idle_hold();
    run("R7 fault", 32'h4300_0000, 2'd0, 1'b0);
    run("R7 allow", 32'h4200_0000, 2'd2, 1'b1);
    chk("R7 hold after allow", 32'(fopc), 32'h43);
    @(negedge clk); insn = 32'hFF00_0000; ring = 2'd3;
    @(negedge clk);
    chk("R6 idle allow", 32'(allow), 0);
    chk("R6 idle fault", 32'(fault), 0);
    chk("R7 hold idle", 32'(fopc), 32'h43);
  endtask

  task automatic t_same_edge();
    @(negedge clk);
    we = 1'b1; waddr = 8'h77; wlvl = 2'd2;
    insn = 32'h7700_0000; valid = 1'b1; ring = 2'd2;
    @(negedge clk); we = 1'b0; valid = 1'b0;
    chk("R8 old level", {30'b0, allow, fault}, 32'b01);
    run("R8 new level", 32'h7700_0000, 2'd2, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unloaded();
    t_matrix();
    t_field();
    t_idle_hold();
    t_same_edge();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule